// File: doc/BRIEF.md
# ECC Partial-Write Policy Controller

This block sits in the write path of an SDRAM controller whose banks may or may not carry error-checking code. For every write request it decides whether the word can go to memory as a single masked write, or whether it must first read the stored word, merge the new bytes into it, compute fresh check bits and write the whole word back. It runs that read-merge-write sequence itself and drives the memory read and write strobes, the per-byte data masks and the check-bit lane.

A 32-bit configuration word selects the protection arrangement, the global ECC switch, the SDRAM data width and one ECC enable per bank, so protected and unprotected banks can share one memory. A separate `shared_mask` input describes boards that route only one common byte-mask line. On such boards a narrow write to an unprotected bank cannot be masked, so it is also turned into a read-merge-write. Error correction on the returned data and SDRAM command timing are handled elsewhere.

Top module: `ecc_wrpolicy_ctrl`

## Requirements
- R1: After reset the configuration word is all zeros, `req_ready` is 1, `busy`, `mem_rd` and `mem_wr` are 0, and a partial write issues no read.
- R2: When configuration bit 1 (global ECC on) is 0, no request ever produces `mem_rd`, whatever the bank bits or `shared_mask` say, and check bits are 0.
- R3: With bit 1 set, bit 0 clear (one protected 64-bit word) and bit 4 clear (64-bit bus), a write to bank b with configuration bit 8+b set and any of its 8 byte enables clear does a read-merge-write; this includes an all-zero enable.
- R4: With bit 1 set, a partial write to a bank whose enable bit is clear and `shared_mask` = 0 is one masked write with `mem_dm` = bitwise inverse of the byte enables (1 = byte not written).
- R5: With bit 1 set and `shared_mask` = 1, any write missing a byte does a read-merge-write, also for banks whose enable bit is clear; a write with all bytes enabled stays a single write.
- R6: A write with every byte enabled never issues a read; it is a single write with `mem_dm` = 0.
- R7: With bit 0 set (two 32-bit protected halves, bytes 0-3 and 4-7), a write to a protected bank does a read-merge-write only if a half has some but not all of its enables set.
- R8: With bit 4 set (32-bit bus), only byte enables 0-3 count, bytes 4-7 are always masked in `mem_dm`, a full word means enables 0-3 all set, and any clear enable among 0-3 makes a protected write a read-merge-write.
- R9: A read-merge-write raises `mem_rd` for exactly one cycle, the cycle after acceptance; it then waits any number of cycles for `rd_valid`, raises `mem_wr` two cycles after the `rd_valid` cycle and returns to idle; `busy` is 1 from the read cycle through the write cycle and requests are accepted only when `req_ready` = 1. A single write appears on `mem_wr` the cycle after acceptance.
- R10: The word written back takes enabled bytes from the request and all other bytes from `rd_data`, with `mem_dm` = 0 (64-bit bus).
- R11: For protected writes `mem_chk` is: in 64-bit protection the XOR of all 8 data bytes; in split mode bits 3:0 fold (high nibble XOR low nibble) the XOR of bytes 0-3 and bits 7:4 fold the XOR of bytes 4-7; on a 32-bit bus bits 3:0 fold the XOR of bytes 0-3 and bits 7:4 are 0.
- R12: `mem_chk` is 0 for any write to a bank whose enable is clear, including forced read-merge-writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shared_mask | input | 1 | Board has a single common byte-mask line |
| cfg_we | input | 1 | Load the configuration word |
| cfg_wdata | input | 32 | New configuration word |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_bank | input | BANK_W (4) | Target bank number |
| req_addr | input | ADDR_W (24) | Word address |
| req_be | input | DATA_W/8 (8) | Byte enables |
| req_data | input | DATA_W (64) | Write data |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DATA_W (64) | Returned word |
| busy | output | 1 | Read-merge-write in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W (24) | Memory word address |
| mem_wdata | output | DATA_W (64) | Memory write data |
| mem_dm | output | DATA_W/8 (8) | Byte masks, 1 = byte not written |
| mem_chk | output | 8 | Check bits for the written word |

## Verification
The bench targets the decision corners: an all-zero enable in 64-bit protection (a design that treats "nothing to write" as full would skip the read and corrupt check bits), split-mode writes with one half full and the other untouched (a design without half tracking would issue needless reads), and the shared-mask case on unprotected banks (a design ignoring it would emit masks the board cannot honour). It also sweeps the 32-bit bus setting, where a design that looked at enables 4-7 would call a full narrow write partial or leave upper bytes unmasked, and varies read latency so a sequencer that writes a fixed number of cycles after the read would write stale data. The global switch is toggled with bank bits set to catch a design that honours bank enables while ECC is off.

// File: rtl/ecc_pw_pkg.sv
package ecc_pw_pkg;

   localparam int CFG_W          = 32;
   localparam int CFG_DUAL_BIT   = 0;
   localparam int CFG_ON_BIT     = 1;
   localparam int CFG_NARROW_BIT = 4;
   localparam int CFG_BANK_LSB   = 8;
   localparam int CHK_W          = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_MERGE,
      ST_WRITE
   } rmw_state_e;

   typedef struct packed {
      logic dual;
      logic narrow;
      logic prot;
   } wr_flags_t;

   function automatic logic [3:0] fold_nib(input logic [7:0] b);
      return b[7:4] ^ b[3:0];
   endfunction

endpackage

// File: rtl/ecc_pw_decide.sv
module ecc_pw_decide
   import ecc_pw_pkg::*;
#(
   parameter int BYTES  = 8,
   parameter int NBANK  = 9,
   parameter int BANK_W = 4
) (
   input  logic [CFG_W-1:0]  cfg,
   input  logic [BANK_W-1:0] bank,
   input  logic [BYTES-1:0]  be,
   input  logic              shared_mask,
   output logic [BYTES-1:0]  be_eff,
   output logic              need_rmw,
   output wr_flags_t         flags
);

   localparam int HALF = BYTES / 2;
   localparam int PAD  = 1 << BANK_W;

   logic [PAD-1:0]  bank_pad;
   logic [HALF-1:0] lo_be, hi_be;
   logic            bank_en, ecc_on, narrow, dual;
   logic            lo_all, lo_none, hi_all, hi_none;
   logic            missing, split_part, ecc_part;

   always_comb begin
      bank_pad = '0;
      bank_pad[NBANK-1:0] = cfg[CFG_BANK_LSB +: NBANK];
   end

   assign bank_en = bank_pad[bank];
   assign ecc_on  = cfg[CFG_ON_BIT];
   assign narrow  = cfg[CFG_NARROW_BIT];
   assign dual    = cfg[CFG_DUAL_BIT];

   assign lo_be   = be[HALF-1:0];
   assign hi_be   = be[BYTES-1:HALF];
   assign be_eff  = narrow ? {{HALF{1'b0}}, lo_be} : be;

   assign lo_all  = &lo_be;
   assign lo_none = ~|lo_be;
   assign hi_all  = &hi_be;
   assign hi_none = ~|hi_be;

   // a byte of the effective word is left out
   assign missing    = narrow ? !lo_all : !(lo_all && hi_all);
   // a protected half is only partly covered
   assign split_part = narrow ? !lo_all
                              : ((!lo_all && !lo_none) || (!hi_all && !hi_none));
   assign ecc_part   = dual ? split_part : missing;

   assign need_rmw = ecc_on && ((bank_en && ecc_part) ||
                                (!bank_en && shared_mask && missing));

   assign flags.dual   = dual;
   assign flags.narrow = narrow;
   assign flags.prot   = ecc_on && bank_en;

endmodule

// File: rtl/ecc_pw_code.sv
module ecc_pw_code
   import ecc_pw_pkg::*;
#(
   parameter int BYTES = 8
) (
   input  logic [8*BYTES-1:0] data,
   input  logic               dual,
   input  logic               narrow,
   output logic [CHK_W-1:0]   chk
);

   localparam int HALF = BYTES / 2;

   logic [HALF:0][7:0] lo_acc, hi_acc;

   assign lo_acc[0] = '0;
   assign hi_acc[0] = '0;

   for (genvar i = 0; i < HALF; i++) begin : g_fold
      assign lo_acc[i+1] = lo_acc[i] ^ data[8*i +: 8];
      assign hi_acc[i+1] = hi_acc[i] ^ data[8*(i+HALF) +: 8];
   end

   always_comb begin
      if (narrow)
         chk = {4'h0, fold_nib(lo_acc[HALF])};
      else if (dual)
         chk = {fold_nib(hi_acc[HALF]), fold_nib(lo_acc[HALF])};
      else
         chk = lo_acc[HALF] ^ hi_acc[HALF];
   end

endmodule

// File: rtl/ecc_pw_merge.sv
module ecc_pw_merge #(
   parameter int BYTES = 8
) (
   input  logic [8*BYTES-1:0] fresh,
   input  logic [8*BYTES-1:0] stale,
   input  logic [BYTES-1:0]   be,
   output logic [8*BYTES-1:0] merged
);

   for (genvar i = 0; i < BYTES; i++) begin : g_byte
      assign merged[8*i +: 8] = be[i] ? fresh[8*i +: 8] : stale[8*i +: 8];
   end

endmodule

// File: rtl/ecc_wrpolicy_ctrl.sv
module ecc_wrpolicy_ctrl
   import ecc_pw_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 64,
   parameter int NBANK  = 9,
   localparam int BYTES  = DATA_W / 8,
   localparam int HALF   = BYTES / 2,
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shared_mask,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BYTES-1:0]  req_be,
   input  logic [DATA_W-1:0] req_data,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [BYTES-1:0]  mem_dm,
   output logic [CHK_W-1:0]  mem_chk
);

   if (DATA_W % 16 != 0 || DATA_W < 16) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of 16");
   end
   if (NBANK < 1 || CFG_BANK_LSB + NBANK > CFG_W) begin : g_bad_banks
      $error("NBANK must fit in the configuration word");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   rmw_state_e        st;
   logic [CFG_W-1:0]  cfg_q;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_data, rd_q, mrg_q, merged;
   logic [BYTES-1:0]  lat_be, be_eff, pw_dm, rmw_dm;
   logic [CHK_W-1:0]  pw_chk, live_chk, rmw_code;
   wr_flags_t         flags, lat_flags;
   logic              need_rmw, plain_q;
   logic              ecc_on_q, rmw_narrow;

   ecc_pw_decide #(.BYTES(BYTES), .NBANK(NBANK), .BANK_W(BANK_W)) i_decide (
      .cfg         (cfg_q),
      .bank        (req_bank),
      .be          (req_be),
      .shared_mask (shared_mask),
      .be_eff      (be_eff),
      .need_rmw    (need_rmw),
      .flags       (flags)
   );

   ecc_pw_code #(.BYTES(BYTES)) i_code_live (
      .data   (req_data),
      .dual   (flags.dual),
      .narrow (flags.narrow),
      .chk    (live_chk)
   );

   ecc_pw_merge #(.BYTES(BYTES)) i_merge (
      .fresh  (lat_data),
      .stale  (rd_q),
      .be     (lat_be),
      .merged (merged)
   );

   ecc_pw_code #(.BYTES(BYTES)) i_code_rmw (
      .data   (mrg_q),
      .dual   (lat_flags.dual),
      .narrow (lat_flags.narrow),
      .chk    (rmw_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cfg_q     <= '0;
         lat_addr  <= '0;
         lat_data  <= '0;
         lat_be    <= '0;
         lat_flags <= '0;
         rd_q      <= '0;
         mrg_q     <= '0;
         plain_q   <= 1'b0;
         pw_dm     <= '0;
         pw_chk    <= '0;
      end else begin
         plain_q <= 1'b0;
         if (cfg_we)
            cfg_q <= cfg_wdata;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  lat_addr  <= req_addr;
                  lat_data  <= req_data;
                  lat_be    <= be_eff;
                  lat_flags <= flags;
                  if (need_rmw) begin
                     st <= ST_READ;
                  end else begin
                     plain_q <= 1'b1;
                     pw_dm   <= ~be_eff;
                     pw_chk  <= flags.prot ? live_chk : '0;
                  end
               end
            end
            ST_READ:  st <= ST_WAIT;
            ST_WAIT: begin
               if (rd_valid) begin
                  rd_q <= rd_data;
                  st   <= ST_MERGE;
               end
            end
            ST_MERGE: begin
               mrg_q <= merged;
               st    <= ST_WRITE;
            end
            ST_WRITE: st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign rmw_dm    = lat_flags.narrow ? {{HALF{1'b1}}, {HALF{1'b0}}} : '0;
   assign req_ready = (st == ST_IDLE);
   assign busy      = (st != ST_IDLE);
   assign mem_rd    = (st == ST_READ);
   assign mem_wr    = plain_q || (st == ST_WRITE);
   assign mem_addr  = lat_addr;
   assign mem_wdata = (st == ST_WRITE) ? mrg_q : lat_data;
   assign mem_dm    = (st == ST_WRITE) ? rmw_dm : pw_dm;
   assign mem_chk   = (st == ST_WRITE) ? (lat_flags.prot ? rmw_code : '0) : pw_chk;

   assign ecc_on_q   = cfg_q[CFG_ON_BIT];
   assign rmw_narrow = lat_flags.narrow;

endmodule

// File: rtl/ecc_wrpolicy_chk.sv
module ecc_wrpolicy_chk #(
   parameter int BYTES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             busy,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic [BYTES-1:0] mem_dm,
   input logic             ecc_on,
   input logic             rmw_narrow
);

   assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && busy));

   assert_rdwr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_accept_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_rd != mem_wr));

   assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   assert_wr_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && busy) |=> !busy);

   assert_off_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !ecc_on) |=> !mem_rd);

   assert_rmw_nomask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && busy && !rmw_narrow) |-> (mem_dm == '0));

endmodule

bind ecc_wrpolicy_ctrl ecc_wrpolicy_chk #(.BYTES(BYTES)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .busy       (busy),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .mem_dm     (mem_dm),
   .ecc_on     (ecc_on_q),
   .rmw_narrow (rmw_narrow)
);

// File: tb/test_ecc_wrpolicy_ctrl.sv
module test_ecc_wrpolicy_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        shared_mask = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_bank = '0;
   logic [23:0] req_addr = '0;
   logic [7:0]  req_be = '0;
   logic [63:0] req_data = '0;
   logic        rd_valid = 1'b0;
   logic [63:0] rd_data = '0;
   logic        busy, mem_rd, mem_wr;
   logic [23:0] mem_addr;
   logic [63:0] mem_wdata;
   logic [7:0]  mem_dm, mem_chk;

   int    tests = 0;
   int    fails = 0;
   string cur_tag = "R1";

   ecc_wrpolicy_ctrl i_ecc_wrpolicy_ctrl (
      .clk(clk), .rst_n(rst_n), .shared_mask(shared_mask),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
      .req_addr(req_addr), .req_be(req_be), .req_data(req_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_dm(mem_dm), .mem_chk(mem_chk)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int ones(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += v[i];
      return n;
   endfunction

   function automatic logic [7:0] bcode(input logic [63:0] d, input bit dual, input bit narrow);
      logic [7:0] lo = '0, hi = '0;
      for (int i = 0; i < 4; i++) lo ^= d[8*i +: 8];
      for (int i = 4; i < 8; i++) hi ^= d[8*i +: 8];
      if (narrow) return {4'h0, lo[7:4] ^ lo[3:0]};
      if (dual)   return {hi[7:4] ^ hi[3:0], lo[7:4] ^ lo[3:0]};
      return lo ^ hi;
   endfunction

   function automatic logic [63:0] bmerge(input logic [63:0] n, input logic [63:0] o, input logic [7:0] be);
      logic [63:0] r = o;
      for (int i = 0; i < 8; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
      return r;
   endfunction

   function automatic bit want_rmw(input logic [31:0] c, input int bank, input logic [7:0] be, input bit sh);
      bit prot, narrow, full;
      int lo, hi;
      if (!c[1]) return 0;
      prot   = (bank < 9) && c[8 + bank];
      narrow = c[4];
      lo     = ones(be & 8'h0F);
      hi     = ones(be >> 4);
      full   = narrow ? (lo == 4) : (lo + hi == 8);
      if (!prot) return sh && !full;
      if (narrow || !c[0]) return !full;
      return (lo != 0 && lo != 4) || (hi != 0 && hi != 4);
   endfunction

   // behavioural reference, advanced on each rising edge
   int          m_st = 0;
   bit          m_plain = 0;
   logic [31:0] m_cfg = '0;
   logic [23:0] m_addr;
   logic [63:0] m_new, m_old, m_mrg;
   logic [7:0]  m_be, m_pdm, m_pchk;
   bit          m_dual, m_narrow, m_prot;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st <= 0; m_plain <= 0; m_cfg <= '0;
      end else begin
         m_plain <= 0;
         if (cfg_we) m_cfg <= cfg_wdata;
         case (m_st)
            0: if (req_valid) begin
                  automatic bit pr = m_cfg[1] && (int'(req_bank) < 9) && m_cfg[8 + int'(req_bank)];
                  automatic logic [7:0] eb = m_cfg[4] ? (req_be & 8'h0F) : req_be;
                  m_addr <= req_addr; m_new <= req_data; m_be <= eb;
                  m_dual <= m_cfg[0]; m_narrow <= m_cfg[4]; m_prot <= pr;
                  if (want_rmw(m_cfg, int'(req_bank), req_be, shared_mask)) m_st <= 1;
                  else begin
                     m_plain <= 1;
                     m_pdm   <= ~eb;
                     m_pchk  <= pr ? bcode(req_data, m_cfg[0], m_cfg[4]) : 8'h00;
                  end
               end
            1: m_st <= 2;
            2: if (rd_valid) begin m_old <= rd_data; m_st <= 3; end
            3: begin m_mrg <= bmerge(m_new, m_old, m_be); m_st <= 4; end
            default: m_st <= 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         automatic logic [3:0] e = {m_st == 1, m_plain || m_st == 4, m_st != 0, m_st == 0};
         automatic logic [3:0] a = {mem_rd, mem_wr, busy, req_ready};
         check(a === e, {cur_tag, " R9 strobes"}, a, e);
         if (m_plain) begin
            automatic logic [103:0] ev = {m_addr, m_new, m_pdm, m_pchk};
            automatic logic [103:0] av = {mem_addr, mem_wdata, mem_dm, mem_chk};
            check(av === ev, {cur_tag, " single write"}, av, ev);
         end else if (m_st == 4) begin
            automatic logic [103:0] ev = {m_addr, m_mrg, (m_narrow ? 8'hF0 : 8'h00),
                                          (m_prot ? bcode(m_mrg, m_dual, m_narrow) : 8'h00)};
            automatic logic [103:0] av = {mem_addr, mem_wdata, mem_dm, mem_chk};
            check(av === ev, {cur_tag, " R10 merged write"}, av, ev);
         end
      end
   end

   task automatic set_cfg(input logic [31:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // chk_on: 1 = check bits expected from the written word, 0 = expected zero
   task automatic do_write(input int bank, input logic [7:0] be, input logic [63:0] d,
                           input logic [63:0] rdv, input bit exp_rmw, input logic [7:0] exp_dm,
                           input bit chk_on, input int lat, input string tag);
      logic [63:0] wword;
      logic [7:0]  echk;
      bit          nar = m_cfg[4];
      bit          dua = m_cfg[0];
      cur_tag = tag;
      @(negedge clk);
      req_valid = 1'b1; req_bank = bank[3:0]; req_be = be; req_data = d;
      req_addr = 24'h0A0000 + 24'(bank) * 24'h10 + 24'(be);
      @(negedge clk);
      req_valid = 1'b0;
      check(mem_rd === exp_rmw, {tag, " read issued"}, mem_rd, exp_rmw);
      wword = d;
      if (exp_rmw) begin
         repeat (1 + lat) begin
            @(negedge clk);
            check(busy && !req_ready, {tag, " R9 busy while waiting"}, {busy, req_ready}, 2'b10);
         end
         rd_valid = 1'b1; rd_data = rdv;
         @(negedge clk);
         rd_valid = 1'b0;
         @(negedge clk);
         wword = bmerge(d, rdv, nar ? (be & 8'h0F) : be);
         check(mem_wdata === wword, {tag, " R10 merged data"}, mem_wdata, wword);
      end
      check(mem_wr === 1'b1, {tag, " write strobe"}, mem_wr, 1'b1);
      check(mem_dm === exp_dm, {tag, " byte mask"}, mem_dm, exp_dm);
      echk = chk_on ? bcode(wword, dua, nar) : 8'h00;
      check(mem_chk === echk, {tag, chk_on ? " R11 check bits" : " R12 zero check bits"}, mem_chk, echk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1'b1);
      check({busy, mem_rd, mem_wr} === 3'b000, "R1 idle strobes", {busy, mem_rd, mem_wr}, 3'b000);
      do_write(0, 8'h0F, 64'h1111_2222_3333_4444, 64'h0, 0, 8'hF0, 0, 0, "R1");

      // R2 global off with every bank bit set
      set_cfg(32'h0001_FF01);
      do_write(2, 8'h3C, 64'hA5A5_0101_2323_4545, 64'h0, 0, 8'hC3, 0, 0, "R2");
      shared_mask = 1'b1;
      do_write(8, 8'h01, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 0, 8'hFE, 0, 0, "R2");
      shared_mask = 1'b0;

      // R3 / R10 one protected 64-bit word, banks 0-7 protected
      set_cfg(32'h0000_FF02);
      do_write(3, 8'h7F, 64'h0102_0304_0506_0708, 64'hFFEE_DDCC_BBAA_9988, 1, 8'h00, 1, 0, "R3");
      do_write(5, 8'h01, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0, 1, 8'h00, 1, 2, "R10");
      do_write(0, 8'h00, 64'h5555_5555_5555_5555, 64'h0F1E_2D3C_4B5A_6978, 1, 8'h00, 1, 1, "R3");
      // R4 unprotected bank masked directly
      do_write(8, 8'h3C, 64'h7777_8888_9999_AAAA, 64'h0, 0, 8'hC3, 0, 0, "R4");
      // R6 full writes
      do_write(1, 8'hFF, 64'h0123_4567_89AB_CDEF, 64'h0, 0, 8'h00, 1, 0, "R6");
      do_write(8, 8'hFF, 64'hFEDC_BA98_7654_3210, 64'h0, 0, 8'h00, 0, 0, "R12");

      // R5 shared mask line
      shared_mask = 1'b1;
      do_write(8, 8'h3C, 64'h1357_9BDF_2468_ACE0, 64'hAAAA_BBBB_CCCC_DDDD, 1, 8'h00, 0, 1, "R5");
      do_write(8, 8'hFF, 64'h2222_4444_6666_8888, 64'h0, 0, 8'h00, 0, 0, "R5");
      do_write(4, 8'h80, 64'h9900_0000_0000_0000, 64'h0011_2233_4455_6677, 1, 8'h00, 1, 0, "R5");
      shared_mask = 1'b0;

      // R7 split protection
      set_cfg(32'h0000_FF03);
      do_write(2, 8'hF0, 64'hAB12_CD34_0000_0000, 64'h0, 0, 8'h0F, 1, 0, "R7");
      do_write(2, 8'h0F, 64'h0000_0000_5566_7788, 64'h0, 0, 8'hF0, 1, 0, "R7");
      do_write(2, 8'h00, 64'h0, 64'h0, 0, 8'hFF, 1, 0, "R7");
      do_write(2, 8'h1F, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 1, 8'h00, 1, 0, "R7");
      do_write(2, 8'hF8, 64'hC0C1_C2C3_C4C5_C6C7, 64'h3030_3030_3030_3030, 1, 8'h00, 1, 3, "R7");
      do_write(2, 8'hFF, 64'h8040_2010_0804_0201, 64'h0, 0, 8'h00, 1, 0, "R11");

      // R8 32-bit bus
      set_cfg(32'h0000_FF12);
      do_write(2, 8'hFF, 64'hFFFF_FFFF_1234_5678, 64'h0, 0, 8'hF0, 1, 0, "R8");
      do_write(2, 8'h0F, 64'h0000_0000_9ABC_DEF0, 64'h0, 0, 8'hF0, 1, 0, "R8");
      do_write(2, 8'h07, 64'h0000_0000_00AA_BBCC, 64'h5A5A_5A5A_DD11_2233, 1, 8'hF0, 1, 0, "R8");
      do_write(2, 8'hF0, 64'h7777_7777_0000_0000, 64'h4444_4444_6666_9999, 1, 8'hF0, 1, 1, "R8");
      set_cfg(32'h0000_FF13);
      do_write(6, 8'h0E, 64'h0000_0000_ABCD_EF00, 64'h0000_0000_0000_0042, 1, 8'hF0, 1, 0, "R11");

      // R9 long read latency, then back to reset configuration
      set_cfg(32'h0000_FF02);
      do_write(7, 8'hEF, 64'h0A0B_0C0D_0E0F_1011, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8'h00, 1, 6, "R9");
      set_cfg(32'h0000_0000);
      do_write(3, 8'h01, 64'h0000_0000_0000_00EE, 64'h0, 0, 8'hFE, 0, 0, "R2");

      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule